// File: doc/BRIEF.md
# Gate Scan Order Generator

This block produces the order in which the gate lines of a display panel are driven during one frame. Three configuration registers hold the active gate count, the scan options and the starting gate. A frame-start pulse takes a snapshot of these registers. The block then offers one gate index at a time on its output until every active gate has been offered once. After the last index it raises a one-cycle done flag.

The output is a valid/ready stream. `gate_valid` stays high for the whole frame, and `gate_idx` carries the gate that is due next. `line_stb` is the ready side: the external line-timing logic drives it when it starts a line. An index is consumed on every rising clock edge where `gate_valid` and `line_stb` are both high. While `line_stb` is low the index is held, so the line timer applies back-pressure simply by not strobing. A strobe while `gate_valid` is low has no effect.

The order is built from a logical line position in three steps. The position first passes through an odd/even split, then through an adjacent-pair swap, and last through a direction reversal. Each step is enabled by its own option bit.

Top module: `gate_scan_order`

## Requirements
- R1: After reset, `gate_valid` and `scan_done` are low. With no configuration writes, a frame offers gates 0, 1, 2, … 299 in that order (count field default 299, start default 0, all options default 0).
- R2: The active gate count N is the count field (address 0) plus one. A frame offers exactly N indices. `scan_done` is high for exactly one cycle, in the cycle after the handshake that consumes the last index. `gate_valid` is low in that cycle and stays low until the next frame start. A frame start while idle raises `gate_valid` in the next cycle.
- R3: The start register (address 2) gives the first logical position. Logical position k of the frame is (k + start) mod N. If start is N or more, the frame starts at position 0.
- R4: When option bit 1 (split) is set, logical position p maps to 2p for p < ceil(N/2). Otherwise it maps to 2(p − ceil(N/2)) + 1. The result is all even gates ascending, then all odd gates ascending.
- R5: When option bit 2 (pair swap) is set, a gate g maps to g XOR 1. The exception is when g XOR 1 is N or more: then g is kept, so the last gate of an odd count stays in place.
- R6: When option bit 0 (reverse) is set, a gate g maps to N − 1 − g.
- R7: The mappings are applied in a fixed order: split first, then pair swap, then reverse.
- R8: A frame start that arrives while a frame is in progress is ignored. The running frame continues unchanged, and only one done pulse follows.
- R9: Configuration writes (on `cfg_wr`, with `cfg_addr` selecting 0 = count field, 1 = options in bits 2:0, 2 = start) take effect only at the next frame start. A write during a frame does not alter the indices of that frame.
- R10: While `gate_valid` is high and `line_stb` is low, `gate_idx` and `gate_valid` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 count field, 1 options, 2 start |
| cfg_wdata | input | 9 | Write data |
| frame_start | input | 1 | Starts a frame when idle |
| line_stb | input | 1 | Ready: consumes the offered index |
| gate_valid | output | 1 | An index is offered |
| gate_idx | output | 9 | Gate index offered |
| scan_done | output | 1 | One-cycle pulse after the last index |

## Verification
The bench runs the full 300-gate default frame, which shows that the power-on values are correct. It then runs short frames with each option bit alone and with all three together. Odd and even counts are used so that the unpaired last gate and the uneven split are told apart, and a start offset is used that exposes the wrong order of the mapping steps. Start offsets both inside and beyond the count separate the wrap rule from the fallback to position 0. Strobe patterns with gaps show back-pressure holding the index. A frame start and a configuration write injected during a running frame show that neither disturbs that frame, and the frame after the write shows that the new setting then applies.

// File: rtl/gso_pkg.sv
package gso_pkg;
  typedef struct packed {
    logic swap;
    logic split;
    logic rev;
  } scan_opts_t;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_OPTS  = 2'd1;
  localparam logic [1:0] ADDR_START = 2'd2;
endpackage

// File: rtl/gso_cfg_regs.sv
module gso_cfg_regs
  import gso_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter logic [IDX_W-1:0] DEF_COUNT = 'h12B,
  parameter logic [IDX_W-1:0] DEF_START = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [IDX_W-1:0] cfg_wdata,
  output logic [IDX_W-1:0] count_field,
  output logic [IDX_W-1:0] start_pos,
  output scan_opts_t       opts
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_field <= DEF_COUNT;
      start_pos   <= DEF_START;
      opts        <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        ADDR_COUNT: count_field <= cfg_wdata;
        ADDR_OPTS:  opts        <= scan_opts_t'(cfg_wdata[2:0]);
        ADDR_START: start_pos   <= cfg_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gso_seq.sv
module gso_seq
  import gso_pkg::*;
#(
  parameter int IDX_W = 9,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             line_stb,
  input  logic [IDX_W-1:0] count_field,
  input  logic [IDX_W-1:0] start_pos,
  input  scan_opts_t       opts_in,
  output logic             active,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] n_cur,
  output scan_opts_t       opts_cur,
  output logic             done
);
  logic [CNT_W-1:0] n_new;
  logic [CNT_W-1:0] start_ext;
  logic [CNT_W-1:0] lines;

  assign n_new     = CNT_W'(count_field) + CNT_W'(1);
  assign start_ext = CNT_W'(start_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      done     <= 1'b0;
      pos      <= '0;
      lines    <= '0;
      n_cur    <= '0;
      opts_cur <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (frame_start) begin
          active   <= 1'b1;
          n_cur    <= n_new;
          opts_cur <= opts_in;
          pos      <= (start_ext < n_new) ? start_ext : '0;
          lines    <= '0;
        end
      end else if (line_stb) begin
        if (lines == n_cur - CNT_W'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          lines <= lines + CNT_W'(1);
          pos   <= (pos == n_cur - CNT_W'(1)) ? '0 : pos + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/gso_map.sv
module gso_map
  import gso_pkg::*;
#(
  parameter int IDX_W = 9,
  localparam int CNT_W = IDX_W + 1,
  localparam int W = IDX_W + 2
) (
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] n,
  input  scan_opts_t       opts,
  output logic [IDX_W-1:0] idx
);
  logic [W-1:0] p, nn, half, q, qx, r, g;

  always_comb begin
    p    = W'(pos);
    nn   = W'(n);
    half = (nn + W'(1)) >> 1;
    if (opts.split)
      q = (p < half) ? (p << 1) : (((p - half) << 1) | W'(1));
    else
      q = p;
    qx = q ^ W'(1);
    r  = (opts.swap && (qx < nn)) ? qx : q;
    g  = opts.rev ? (nn - W'(1) - r) : r;
  end

  assign idx = IDX_W'(g);
endmodule

// File: rtl/gate_scan_order.sv
module gate_scan_order
  import gso_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter logic [IDX_W-1:0] DEF_COUNT = 'h12B,
  parameter logic [IDX_W-1:0] DEF_START = '0,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [IDX_W-1:0] cfg_wdata,
  input  logic             frame_start,
  input  logic             line_stb,
  output logic             gate_valid,
  output logic [IDX_W-1:0] gate_idx,
  output logic             scan_done
);
  logic [IDX_W-1:0] count_field, start_pos;
  scan_opts_t       opts_reg, opts_cur;
  logic [CNT_W-1:0] pos, n_cur;

  gso_cfg_regs #(.IDX_W(IDX_W), .DEF_COUNT(DEF_COUNT), .DEF_START(DEF_START)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .count_field(count_field), .start_pos(start_pos),
    .opts(opts_reg)
  );

  gso_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_stb(line_stb),
    .count_field(count_field), .start_pos(start_pos), .opts_in(opts_reg),
    .active(gate_valid), .pos(pos), .n_cur(n_cur), .opts_cur(opts_cur),
    .done(scan_done)
  );

  gso_map #(.IDX_W(IDX_W)) u_map (
    .pos(pos), .n(n_cur), .opts(opts_cur), .idx(gate_idx)
  );
endmodule

// File: rtl/gso_checker.sv
module gso_checker #(
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             line_stb,
  input logic             gate_valid,
  input logic [IDX_W-1:0] gate_idx,
  input logic             scan_done
);
  AST_HOLD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    gate_valid && !line_stb |=> gate_valid && $stable(gate_idx)); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    gate_valid && frame_start && !line_stb |=> gate_valid && $stable(gate_idx)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done); // R2

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !gate_valid && $past(gate_valid && line_stb)); // R2

  AST_START_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_valid && frame_start |=> gate_valid); // R2
endmodule

bind gate_scan_order gso_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_stb(line_stb),
  .gate_valid(gate_valid), .gate_idx(gate_idx), .scan_done(scan_done)
);

// File: tb/tb_gate_scan_order.sv
module tb_gate_scan_order;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_wr = 0;
  logic [1:0] cfg_addr = 0;
  logic [8:0] cfg_wdata = 0;
  logic       frame_start = 0;
  logic       line_stb = 0;
  logic       gate_valid;
  logic [8:0] gate_idx;
  logic       scan_done;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string cur_tag = "R1";
  bit done_seen = 0;

  always #5 clk = ~clk;

  gate_scan_order dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .line_stb(line_stb),
    .gate_valid(gate_valid), .gate_idx(gate_idx), .scan_done(scan_done)
  );

  function automatic int model(int n, int st, bit sw, bit sp, bit rv, int k);
    int p, half, q, r;
    if (st >= n) st = 0;
    p = (k + st) % n;
    half = (n + 1) / 2;
    q = sp ? ((p < half) ? 2 * p : 2 * (p - half) + 1) : p;
    r = (sw && ((q ^ 1) < n)) ? (q ^ 1) : q;
    return rv ? (n - 1 - r) : r;
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic expect_frame(int n, int st, bit sw, bit sp, bit rv, string tag);
    cur_tag = tag;
    for (int k = 0; k < n; k++) exp_q.push_back(model(n, st, sw, sp, rv, k));
  endtask

  task automatic write_cfg(logic [1:0] a, int d);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_addr = a; cfg_wdata = 9'(d);
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  // kind: 0 none, 1 frame start mid-frame, 2 option write (all options) mid-frame
  task automatic play(int gap_mod, int kind, int at);
    int cyc = 0;
    done_seen = 0;
    @(posedge clk); #1;
    frame_start = 1;
    while (!done_seen && cyc < 5000) begin
      @(posedge clk); #1;
      frame_start = (kind == 1 && cyc == at);
      cfg_wr      = (kind == 2 && cyc == at);
      cfg_addr    = 2'd1;
      cfg_wdata   = 9'd7;
      line_stb    = (gap_mod == 0) ? 1'b1 : ((cyc % gap_mod) != 0);
      cyc++;
    end
    line_stb = 0; frame_start = 0; cfg_wr = 0;
    check({cur_tag, " done seen"}, int'(done_seen), 1);
    check({cur_tag, " queue drained"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (2) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (gate_valid) begin
        if (exp_q.size() == 0) begin
          check({cur_tag, " extra index"}, int'(gate_idx), -1);
        end else if (line_stb) begin
          check(cur_tag, int'(gate_idx), exp_q.pop_front());
        end else begin
          check({cur_tag, " R10 hold"}, int'(gate_idx), exp_q[0]);
        end
      end
      if (scan_done) begin
        done_seen = 1;
        check({cur_tag, " R2 count at done"}, exp_q.size(), 0);
        check({cur_tag, " R2 valid low at done"}, int'(gate_valid), 0);
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 valid after reset", int'(gate_valid), 0);
    check("R1 done after reset", int'(scan_done), 0);

    expect_frame(300, 0, 0, 0, 0, "R1 default frame");
    play(0, 0, 0);

    write_cfg(2'd0, 9);
    expect_frame(10, 0, 0, 0, 0, "R2 count ten");
    play(3, 0, 0);

    write_cfg(2'd2, 7);
    expect_frame(10, 7, 0, 0, 0, "R3 start wrap");
    play(4, 0, 0);

    write_cfg(2'd2, 20);
    expect_frame(10, 20, 0, 0, 0, "R3 start beyond count");
    play(0, 0, 0);

    write_cfg(2'd2, 0);
    write_cfg(2'd1, 2);
    expect_frame(10, 0, 0, 1, 0, "R4 split even count");
    play(2, 0, 0);
    write_cfg(2'd0, 6);
    expect_frame(7, 0, 0, 1, 0, "R4 split odd count");
    play(0, 0, 0);

    write_cfg(2'd1, 4);
    expect_frame(7, 0, 1, 0, 0, "R5 swap odd count");
    play(0, 0, 0);

    write_cfg(2'd1, 1);
    write_cfg(2'd0, 7);
    expect_frame(8, 0, 0, 0, 1, "R6 reverse");
    play(3, 0, 0);

    write_cfg(2'd1, 7);
    write_cfg(2'd0, 8);
    write_cfg(2'd2, 3);
    expect_frame(9, 3, 1, 1, 1, "R7 all options");
    play(0, 0, 0);

    write_cfg(2'd0, 0);
    write_cfg(2'd2, 0);
    expect_frame(1, 0, 1, 1, 1, "R2 single gate");
    play(0, 0, 0);

    write_cfg(2'd1, 0);
    write_cfg(2'd0, 9);
    expect_frame(10, 0, 0, 0, 0, "R8 restart ignored");
    play(2, 1, 4);

    expect_frame(10, 0, 0, 0, 0, "R9 write mid frame");
    play(0, 2, 3);
    expect_frame(10, 0, 1, 1, 1, "R9 write applied next frame");
    play(0, 0, 0);

    finish_run();
  end
endmodule